// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Coherent Byte Reads

This block is a 16-bit free-running up-counter that software reaches over an 8-bit register bus. The count is presented as a high byte and a low byte. A control register selects where the count steps come from (nothing, the bus clock, a slow fixed reference, or an external input) and a power-of-two prescale divisor between 1 and 128. The two slow sources arrive as raw levels. They are synchronized into the bus clock domain, and each rising edge becomes one step enable.

An 8-bit bus cannot fetch 16 bits in one access, so the block makes both bytes agree. The first read of either count byte freezes a copy of the whole count. Later count reads return that copy until the opposite byte has been read, and then the block goes back to showing the live count. Any write to a count byte or to the control register drops a pending copy. A write to the high byte also zeroes the counter.

Top module: `prescaled_count_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter is 0, the control register reads 0x00 (no clock source, divisor 1) and no snapshot is held.
- R2: Register map by `bus_addr`: 0 = control, with bits [4:3] the source select, bits [2:0] the prescale code and the upper bits reading 0; 1 = count high byte; 2 = count low byte; 3 reads 0. `bus_rdata` is combinational and is valid in the same cycle as `bus_rd`. Control writes take effect at the next clock edge.
- R3: Source select 00 means no clock: the counter and the prescaler hold. Source 01 means the bus clock, which gives a step enable on every cycle.
- R4: With prescale code p (000 to 111), the counter advances once per 2^p step enables. Every control write restarts the prescaler from zero.
- R5: A write of any value to the count high byte clears the whole counter at the next edge. A write to the count low byte leaves the counter unchanged.
- R6: A count-byte read with no snapshot held returns the live byte and captures all 16 bits. Until the opposite byte is read, every count-byte read returns the captured value. Reading the opposite byte returns its captured half and releases the snapshot.
- R7: A write to the control register, the count high byte or the count low byte releases any held snapshot, so the next count read shows the live value.
- R8: Source 10 (fixed reference) and source 11 (external input) are synchronized through two flip-flops. Each rising edge gives exactly one step enable, and the input that is not selected has no effect. Each input level must last at least two bus cycles.
- R9: The counter wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; ignored when `bus_wr` is high |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| fix_clk_in | input | 1 | Fixed reference clock level, asynchronous |
| ext_clk_in | input | 1 | External clock level, asynchronous |

## Verification
Read data is due in the same cycle as the read strobe. The monitor samples it at the falling edge of that cycle, and the driver pushes each expected byte at the moment it raises the strobe. A write to the control register or the count takes effect at the following rising edge. On the bus-clock source, the first step after a control write lands on the next edge. A bench reference model runs on the same rising edges as the design, so each expected value already includes every register on the path. The synchronized sources add three cycles from an input rising edge to the counter step. For those sources the bench stops toggling and waits well past that delay before it reads a count it has worked out by hand.

// File: rtl/tmr_pkg.sv
// Package: shared types and register addresses for the prescaled timer.
// Assumes a 2-bit register address space on an 8-bit bus.
package tmr_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_BUS  = 2'b01,
        SRC_FIX  = 2'b10,
        SRC_EXT  = 2'b11
    } clk_src_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNTH = 2'd1;
    localparam logic [1:0] ADDR_CNTL = 2'd2;
endpackage

// File: rtl/tmr_src_sel.sv
// Module: tmr_src_sel
// Synchronizes the fixed and external clock levels, turns each rising edge
// into a one-cycle pulse and selects the step-enable source.
// Assumes each input level lasts at least two bus cycles.
module tmr_src_sel
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_src_e src,
    input  logic     fix_in,
    input  logic     ext_in,
    output logic     src_en
);
    logic [1:0] raw_lvl;
    logic [1:0] edge_pulse;

    assign raw_lvl = {ext_in, fix_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        logic [SYNC_STAGES:0] sh_q;

        // Shift the raw level through the synchronizer plus one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-1:0], raw_lvl[g]};
        end

        assign edge_pulse[g] = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

        AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            edge_pulse[g] |=> !edge_pulse[g]); // R8
    end

    // Pick the step enable named by the source select.
    always_comb begin
        case (src)
            SRC_BUS:  src_en = 1'b1;
            SRC_FIX:  src_en = edge_pulse[0];
            SRC_EXT:  src_en = edge_pulse[1];
            default:  src_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_prescale.sv
// Module: tmr_prescale
// Power-of-two prescaler: counts step enables and emits a tick when the low
// bits chosen by the prescale code are all ones. Restart clears it.
module tmr_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_en,
    input  logic [PS_W-1:0] ps,
    input  logic            restart,
    output logic            tick
);
    localparam int PRE_W = (1 << PS_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   one_sh;
    logic [PRE_W-1:0] mask;

    // Build the mask of prescaler bits that must be all ones.
    always_comb begin
        one_sh = {{PRE_W{1'b0}}, 1'b1} << ps;
        mask   = one_sh[PRE_W-1:0] - {{(PRE_W-1){1'b0}}, 1'b1};
    end

    assign tick = src_en && ((pre_q & mask) == mask);

    // Advance on each step enable; a control write restarts from zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else if (src_en)  pre_q <= pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
    end

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> pre_q == '0); // R4
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !src_en) |=> $stable(pre_q)); // R3
endmodule

// File: rtl/tmr_count_latch.sv
// Module: tmr_count_latch
// The counter plus its read-coherency snapshot. Presents either the live
// count or the snapshot on cnt_view. Assumes at most one read per cycle.
module tmr_count_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_cnt,
    input  logic             coh_clr,
    input  logic             rd_hi,
    input  logic             rd_lo,
    output logic [CNT_W-1:0] cnt_view
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] snap_q;
    logic             lat_q;
    logic             first_hi_q;

    // Count up on each tick; a high-byte write clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr_cnt) cnt_q <= '0;
        else if (tick)    cnt_q <= cnt_q + CNT_W'(1);
    end

    // Take a snapshot on the first byte read, release it on the other byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q      <= 1'b0;
            snap_q     <= '0;
            first_hi_q <= 1'b0;
        end else if (coh_clr) begin
            lat_q <= 1'b0;
        end else if (rd_hi || rd_lo) begin
            if (!lat_q) begin
                lat_q      <= 1'b1;
                snap_q     <= cnt_q;
                first_hi_q <= rd_hi;
            end else if (rd_hi != first_hi_q) begin
                lat_q <= 1'b0;
            end
        end
    end

    assign cnt_view = lat_q ? snap_q : cnt_q;

    AST_CLEAR_ON_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> cnt_q == '0); // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr_cnt) |=> $stable(cnt_q)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_cnt) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R9
    AST_UNLATCH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        coh_clr |=> !lat_q); // R7
    AST_SNAPSHOT_ON_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_hi || rd_lo) && !lat_q && !coh_clr) |=> (lat_q && snap_q == $past(cnt_q))); // R6
endmodule

// File: rtl/prescaled_count_timer.sv
// Module: prescaled_count_timer (top)
// Register front end of the prescaled 16-bit timer: decodes the 8-bit bus,
// holds the control register and ties together source select, prescaler
// and counter. Assumes one bus access per cycle; a write wins over a read.
module prescaled_count_timer
    import tmr_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int PS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              fix_clk_in,
    input  logic              ext_clk_in
);
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int CTRL_PAD = BYTE_W - PS_W - 2;

    clk_src_e         src_q;
    logic [PS_W-1:0]  ps_q;
    logic             wr_ctrl, wr_hi, wr_lo, rd_ok;
    logic             src_en, tick;
    logic [CNT_W-1:0] cnt_view;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[BYTE_W-1:PS_W+2];

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_hi   = bus_wr && (bus_addr == ADDR_CNTH);
    assign wr_lo   = bus_wr && (bus_addr == ADDR_CNTL);
    assign rd_ok   = bus_rd && !bus_wr;

    // Control register: source select and prescale code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_NONE;
            ps_q  <= '0;
        end else if (wr_ctrl) begin
            src_q <= clk_src_e'(bus_wdata[PS_W+1:PS_W]);
            ps_q  <= bus_wdata[PS_W-1:0];
        end
    end

    tmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src_q),
        .fix_in (fix_clk_in),
        .ext_in (ext_clk_in),
        .src_en (src_en)
    );

    tmr_prescale #(.PS_W(PS_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_en  (src_en),
        .ps      (ps_q),
        .restart (wr_ctrl),
        .tick    (tick)
    );

    tmr_count_latch #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr_cnt  (wr_hi),
        .coh_clr  (wr_ctrl || wr_hi || wr_lo),
        .rd_hi    (rd_ok && (bus_addr == ADDR_CNTH)),
        .rd_lo    (rd_ok && (bus_addr == ADDR_CNTL)),
        .cnt_view (cnt_view)
    );

    // Read mux, combinational from the address.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {{CTRL_PAD{1'b0}}, src_q, ps_q};
            ADDR_CNTH: bus_rdata = cnt_view[CNT_W-1:BYTE_W];
            ADDR_CNTL: bus_rdata = cnt_view[BYTE_W-1:0];
            default:   bus_rdata = '0;
        endcase
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ps_q == $past(bus_wdata[PS_W-1:0])); // R2
    AST_NO_SOURCE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_NONE) |-> !tick); // R3
endmodule

// File: tb/tb_prescaled_count_timer.sv
`timescale 1ns/1ps
module tb_prescaled_count_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       fix_clk_in = 1'b0, ext_clk_in = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    prescaled_count_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fix_clk_in(fix_clk_in), .ext_clk_in(ext_clk_in)
    );

    // Reference model of the bus-clock mode, built from the requirements.
    logic [1:0]  m_src;
    logic [2:0]  m_ps;
    logic [6:0]  m_pre;
    logic [15:0] m_cnt, m_buf;
    logic        m_lat, m_first_hi;

    function automatic logic [6:0] ps_mask(input logic [2:0] p);
        return 7'((8'd1 << p) - 8'd1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src <= 2'd0; m_ps <= 3'd0; m_pre <= 7'd0; m_cnt <= 16'd0;
            m_buf <= 16'd0; m_lat <= 1'b0; m_first_hi <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == 2'd0) begin
                m_src <= bus_wdata[4:3]; m_ps <= bus_wdata[2:0]; m_pre <= 7'd0;
            end else if (m_src == 2'd1) m_pre <= m_pre + 7'd1;
            if (bus_wr && bus_addr == 2'd1) m_cnt <= 16'd0;
            else if (m_src == 2'd1 && ((m_pre & ps_mask(m_ps)) == ps_mask(m_ps)))
                m_cnt <= m_cnt + 16'd1;
            if (bus_wr && bus_addr != 2'd3) m_lat <= 1'b0;
            else if (bus_rd && (bus_addr == 2'd1 || bus_addr == 2'd2)) begin
                if (!m_lat) begin
                    m_lat <= 1'b1; m_buf <= m_cnt; m_first_hi <= (bus_addr == 2'd1);
                end else if ((bus_addr == 2'd1) != m_first_hi) m_lat <= 1'b0;
            end
        end
    end

    logic [7:0] exp_q[$];
    string      tag_q[$];

    function automatic logic [7:0] model_rd(input logic [1:0] a);
        logic [15:0] v;
        v = m_lat ? m_buf : m_cnt;
        case (a)
            2'd0: return {3'b000, m_src, m_ps};
            2'd1: return v[15:8];
            2'd2: return v[7:0];
            default: return 8'd0;
        endcase
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_wr = 1'b0; bus_rd = 1'b0;
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic do_read_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
    endtask

    task automatic do_read(input logic [1:0] a, input string tag);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(model_rd(a)); tag_q.push_back(tag);
    endtask

    // Monitor: compare each read at the falling edge of its cycle.
    always @(negedge clk) begin
        if (bus_rd && !bus_wr && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            vectors++;
            if (bus_rdata !== e) begin
                miscompares++;
                $display("FAIL %s addr=%0d actual=%02h expected=%02h", t, bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            miscompares++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic pulse_input(input bit use_ext, input int n);
        for (int i = 0; i < n; i++) begin
            if (use_ext) ext_clk_in = 1'b1; else fix_clk_in = 1'b1;
            idle(3);
            if (use_ext) ext_clk_in = 1'b0; else fix_clk_in = 1'b0;
            idle(3);
        end
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1: reset state
        do_read(2'd0, "R1 ctrl after reset");
        do_read(2'd1, "R1 count high after reset");
        do_read(2'd2, "R1 count low after reset");
        do_read(2'd3, "R2 unused address");
        // R3: no clock holds
        idle(6);
        do_read(2'd2, "R3 hold with no source");
        do_read(2'd1, "R3 hold with no source");
        // R2/R3: bus clock, divisor 1
        do_write(2'd0, 8'h08);
        do_read(2'd0, "R2 ctrl readback");
        idle(10);
        do_read(2'd2, "R3 bus clock low");
        idle(3);
        do_read(2'd2, "R6 repeat low is buffered");
        do_read(2'd1, "R6 other byte from buffer");
        do_read(2'd2, "R6 new live low");
        do_read(2'd1, "R6 paired high");
        // R5: high write clears, low write does not
        do_write(2'd1, 8'hA5);
        do_read(2'd2, "R5 cleared low");
        do_read(2'd1, "R5 cleared high");
        idle(7);
        do_write(2'd2, 8'h55);
        do_read(2'd2, "R5 low write leaves count");
        do_read(2'd1, "R5 low write leaves count");
        // R7: writes release the snapshot
        do_read(2'd1, "R7 latch via high");
        idle(4);
        do_write(2'd2, 8'h00);
        do_read(2'd1, "R7 live after low write");
        idle(5);
        do_write(2'd0, 8'h08);
        do_read(2'd2, "R7 live after ctrl write");
        idle(5);
        do_write(2'd1, 8'h00);
        idle(3);
        do_read(2'd2, "R7 live after high write");
        do_read(2'd1, "R7 pair high");
        // R4: every prescale code
        for (int p = 1; p < 8; p++) begin
            do_write(2'd0, 8'h08 | 8'(p));
            do_write(2'd1, 8'h00);
            idle(300 + p * 3);
            do_read(2'd2, "R4 prescaled low");
            do_read(2'd1, "R4 prescaled high");
            idle(2);
            do_write(2'd0, 8'h08 | 8'(p));
            idle(p * 5);
            do_read(2'd2, "R4 prescaler restart");
            do_read(2'd1, "R4 prescaler restart");
        end
        // R6: snapshot across a carry into the high byte
        do_write(2'd0, 8'h08);
        do_write(2'd1, 8'h00);
        idle(250);
        do_read(2'd2, "R6 low before carry");
        idle(20);
        do_read(2'd1, "R6 high stays coherent");
        do_read(2'd1, "R6 high live after release");
        do_read(2'd2, "R6 pair low");
        // R9: wrap
        do_write(2'd1, 8'h00);
        idle(65520);
        for (int k = 0; k < 12; k++) begin
            do_read(2'd2, "R9 wrap low");
            do_read(2'd1, "R9 wrap high");
        end
        // R8: fixed reference, divisor 1, external toggling ignored
        do_write(2'd0, 8'h10);
        do_write(2'd1, 8'h00);
        idle(4);
        fork
            pulse_input(1'b0, 6);
            begin idle(1); pulse_input(1'b1, 4); end
        join
        idle(8);
        do_read_exp(2'd2, 8'd6, "R8 fixed edges counted");
        do_read_exp(2'd1, 8'd0, "R8 fixed edges counted");
        // R8: external input, divisor 2
        do_write(2'd0, 8'h19);
        do_write(2'd1, 8'h00);
        idle(4);
        pulse_input(1'b1, 10);
        idle(8);
        do_read_exp(2'd2, 8'd5, "R8 external edges divided");
        do_read_exp(2'd1, 8'd0, "R8 external edges divided");
        do_write(2'd0, 8'h00);
        idle(4);
        finish_run();
    end
endmodule